// File: doc/BRIEF.md
# Multi-core IPI mailbox controller

This register block carries inter-processor interrupts across a cluster of cores. The cores are organised into groups. Every core owns a small set of registers: a pending word, a mask word, a write-one-to-set port, a write-one-to-clear port and a four-slot array of 64-bit message words. Any core can raise pending bits on another core through that core's set port. The receiving core reads its pending word and writes the same value back to its clear port, which acknowledges every bit it has seen in one access. The message slots carry extra data with an interrupt. During boot handoff they hold the arguments. The start address goes into slot 0 last, and the target core writes zero to slot 0 once it is running.

Access uses a simple memory-mapped port. It has one address, write data, a transfer-size bit, and read and write strobes. Read data is registered. The block drives one interrupt line per core. Each line is high while the core's pending word ANDed with its mask word is nonzero.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: After reset, every pending word, mask word and message slot reads zero, and every interrupt line is low.
- R2: A 32-bit write to offset 0x08 sets each pending bit of the addressed core whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A 32-bit write to offset 0x0C clears each pending bit of the addressed core whose write-data bit is 1. Writing back the full pending value read from offset 0x00 clears all of those bits.
- R4: The mask word is read and written with 32-bit transfers at offset 0x04. Interrupt line i is high exactly when pending(i) AND mask(i) is nonzero. The line reflects a register write from the first cycle after that write.
- R5: Message slot k (k = 0..3) sits at offset 0x20 + 8*k and is accessed with 64-bit transfers. Each slot keeps its value until that slot is written, independent of the other slots.
- R6: A read returns data on rdata in the cycle after the read strobe. Reads of offsets 0x08 and 0x0C return zero.
- R7: An access whose size does not match the target is ignored on write and returns zero on read. The 32-bit registers need size bit 0, and the message slots need size bit 1. An access to an unmapped offset is treated the same way.
- R8: Address bits [9:8] select the group and bits [7:6] select the core within the group, so the core number is addr[9:6]. A write changes only the addressed core's registers.
- R9: The pending word at offset 0x00 is read-only. A write there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 10 | Group, core and register offset |
| wdata | input | 64 | Write data; 32-bit registers use bits [31:0] |
| wide | input | 1 | Transfer size: 0 = 32-bit, 1 = 64-bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 64 | Registered read data |
| irq | output | 16 | One interrupt line per core |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that no access is made during reset, so each register changes only under the single decoded write of a cycle. The bench drives each access for exactly one cycle and keeps the strobes apart. It also exercises wrong-size and read-only accesses, which checks that the hold assertions still apply when the decoder rejects a transfer.

// File: rtl/ipi_mbox_pkg.sv
// Shared widths and the register-kind encoding for the IPI mailbox block.
package ipi_mbox_pkg;
    localparam int IPI_W      = 32;  // pending / mask word width
    localparam int MSG_W      = 64;  // message slot width
    localparam int MSG_SLOTS  = 4;   // message slots per core
    localparam int OFF_W      = 6;   // register offset field width
    localparam int SLOT_W     = $clog2(MSG_SLOTS);

    localparam logic [OFF_W-1:0] OFF_PEND  = 6'h00;
    localparam logic [OFF_W-1:0] OFF_MASK  = 6'h04;
    localparam logic [OFF_W-1:0] OFF_SET   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_CLR   = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_MSG   = 6'h20;

    typedef enum logic [2:0] {
        K_NONE, K_PEND, K_MASK, K_SET, K_CLR, K_MSG
    } reg_kind_t;

    typedef logic [MSG_SLOTS-1:0][MSG_W-1:0] msg_arr_t;
endpackage

// File: rtl/ipi_addr_decode.sv
// Splits an access address into a core number, a register kind and a
// message slot. Assumes the core count per group is a power of two, so
// the core number is the concatenation of the group and core fields.
// Size-mismatched or unmapped accesses decode to K_NONE.
module ipi_addr_decode
    import ipi_mbox_pkg::*;
#(
    parameter int CORE_IW = 4,
    parameter int AW      = CORE_IW + OFF_W
) (
    input  logic [AW-1:0]      addr,
    input  logic               wide,
    output logic [CORE_IW-1:0] core_idx,
    output reg_kind_t          kind,
    output logic [SLOT_W-1:0]  slot
);
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] msg_rel;

    assign off      = addr[OFF_W-1:0];
    assign core_idx = addr[AW-1:OFF_W];
    assign msg_rel  = off - OFF_MSG;

    // Classify the offset and check the transfer size against it.
    always_comb begin
        kind = K_NONE;
        slot = msg_rel[SLOT_W+2:3];
        if (!wide) begin
            unique case (off)
                OFF_PEND: kind = K_PEND;
                OFF_MASK: kind = K_MASK;
                OFF_SET:  kind = K_SET;
                OFF_CLR:  kind = K_CLR;
                default:  kind = K_NONE;
            endcase
        end else if (off >= OFF_MSG && msg_rel[2:0] == 3'd0 &&
                     (msg_rel >> 3) < OFF_W'(MSG_SLOTS)) begin
            kind = K_MSG;
        end
    end
endmodule

// File: rtl/ipi_core_regs.sv
// Register set of one core: pending word with set/clear ports, mask word
// and message slots. Drives the core's interrupt line. Assumes at most
// one write per cycle, presented with sel and wr together.
module ipi_core_regs
    import ipi_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  reg_kind_t         kind,
    input  logic [SLOT_W-1:0] slot,
    input  logic [MSG_W-1:0]  wdata,
    output logic [IPI_W-1:0]  pend,
    output logic [IPI_W-1:0]  mask,
    output msg_arr_t          msg,
    output logic              irq
);
    logic [IPI_W-1:0] w32;
    logic             hit;

    assign w32 = wdata[IPI_W-1:0];
    assign hit = sel && wr;

    // Update pending, mask and message storage on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= '0;
            msg  <= '0;
        end else if (hit) begin
            case (kind)
                K_MASK:  mask <= w32;
                K_SET:   pend <= pend | w32;
                K_CLR:   pend <= pend & ~w32;
                K_MSG:   msg[slot] <= wdata;
                default: ;
            endcase
        end
    end

    // Interrupt line: any pending bit that is also unmasked.
    assign irq = |(pend & mask);

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == K_SET) |=> ((pend & $past(w32)) == $past(w32)));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == K_CLR) |=> ((pend & $past(w32)) == '0));

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && (kind == K_SET || kind == K_CLR)) |=> $stable(pend));

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && kind == K_MASK) |=> $stable(mask));

    p_msg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && kind == K_MSG) |=> $stable(msg));
endmodule

// File: rtl/ipi_read_mux.sv
// Registered read path: selects the addressed core's register on a read
// strobe and holds rdata otherwise. Write-only ports and rejected
// accesses read as zero.
module ipi_read_mux
    import ipi_mbox_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int CORE_IW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [CORE_IW-1:0]            core_idx,
    input  reg_kind_t                     kind,
    input  logic [SLOT_W-1:0]             slot,
    input  logic [N_CORES-1:0][IPI_W-1:0] pend_all,
    input  logic [N_CORES-1:0][IPI_W-1:0] mask_all,
    input  msg_arr_t [N_CORES-1:0]        msg_all,
    output logic [MSG_W-1:0]              rdata
);
    // Capture the selected value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (kind)
                K_PEND:  rdata <= MSG_W'(pend_all[core_idx]);
                K_MASK:  rdata <= MSG_W'(mask_all[core_idx]);
                K_MSG:   rdata <= msg_all[core_idx][slot];
                default: rdata <= '0;
            endcase
        end
    end

    p_port_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (kind == K_SET || kind == K_CLR)) |=> (rdata == '0));

    p_bad_access_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_NONE) |=> (rdata == '0));
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
// Top of the IPI mailbox controller: decodes the access, fans the write
// out to one register set per core and returns registered read data.
// Assumes rd_en and wr_en are never high in the same cycle.
module ipi_mailbox_ctrl
    import ipi_mbox_pkg::*;
#(
    parameter int N_GROUPS        = 4,
    parameter int CORES_PER_GROUP = 4,
    localparam int N_CORES = N_GROUPS * CORES_PER_GROUP,
    localparam int CORE_IW = $clog2(N_GROUPS) + $clog2(CORES_PER_GROUP),
    localparam int AW      = CORE_IW + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr,
    input  logic [MSG_W-1:0]   wdata,
    input  logic               wide,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [MSG_W-1:0]   rdata,
    output logic [N_CORES-1:0] irq
);
    logic [CORE_IW-1:0]            core_idx;
    reg_kind_t                     kind;
    logic [SLOT_W-1:0]             slot;
    logic [N_CORES-1:0][IPI_W-1:0] pend_all;
    logic [N_CORES-1:0][IPI_W-1:0] mask_all;
    msg_arr_t [N_CORES-1:0]        msg_all;

    ipi_addr_decode #(.CORE_IW(CORE_IW), .AW(AW)) dec_i (
        .addr(addr), .wide(wide),
        .core_idx(core_idx), .kind(kind), .slot(slot)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        ipi_core_regs regs_i (
            .clk(clk), .rst_n(rst_n),
            .sel(core_idx == CORE_IW'(c)), .wr(wr_en),
            .kind(kind), .slot(slot), .wdata(wdata),
            .pend(pend_all[c]), .mask(mask_all[c]),
            .msg(msg_all[c]), .irq(irq[c])
        );
    end

    ipi_read_mux #(.N_CORES(N_CORES), .CORE_IW(CORE_IW)) rmux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .core_idx(core_idx), .kind(kind), .slot(slot),
        .pend_all(pend_all), .mask_all(mask_all), .msg_all(msg_all),
        .rdata(rdata)
    );

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
endmodule

// File: tb/ipi_mailbox_ctrl_tb_top.sv
// Scoreboard bench: read tasks queue the expected word, a monitor compares
// rdata one cycle after each read strobe.
module ipi_mailbox_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [9:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        wide = 0;
    logic        wr_en = 0;
    logic        rd_en = 0;
    logic [63:0] rdata;
    logic [15:0] irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pend [16];
    logic [31:0] m_mask [16];
    logic [63:0] m_msg  [16][4];

    logic [63:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 0;

    always #2.5 clk = ~clk;

    ipi_mailbox_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wide(wide),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
    );

    // Monitor: rdata is valid the cycle after the strobe (R6).
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input int core, input logic [5:0] off,
                      input logic w, input logic [63:0] d);
        @(negedge clk);
        addr = {core[3:0], off}; wide = w; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        // model
        if (!w) begin
            case (off)
                6'h04: m_mask[core] = d[31:0];
                6'h08: m_pend[core] = m_pend[core] | d[31:0];
                6'h0C: m_pend[core] = m_pend[core] & ~d[31:0];
                default: ;
            endcase
        end else if (off >= 6'h20 && off[2:0] == 0) begin
            m_msg[core][(off - 6'h20) >> 3] = d;
        end
    endtask

    task automatic rd(input int core, input logic [5:0] off,
                      input logic w, input string t);
        logic [63:0] e;
        e = '0;
        if (!w && off == 6'h00) e = {32'h0, m_pend[core]};
        else if (!w && off == 6'h04) e = {32'h0, m_mask[core]};
        else if (w && off >= 6'h20 && off[2:0] == 0)
            e = m_msg[core][(off - 6'h20) >> 3];
        @(negedge clk);
        addr = {core[3:0], off}; wide = w; rd_en = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic chk_irq(input string t);
        logic [15:0] e;
        for (int i = 0; i < 16; i++) e[i] = |(m_pend[i] & m_mask[i]);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%h expected=%h", t, irq, e);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_pend[i] = '0; m_mask[i] = '0;
            for (int k = 0; k < 4; k++) m_msg[i][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk_irq("R1 reset irq");
        rd(0, 6'h00, 0, "R1 pend");
        rd(7, 6'h04, 0, "R1 mask");
        rd(12, 6'h38, 1, "R1 msg");
        // R2: set port
        wr(3, 6'h08, 0, 64'h5);
        rd(3, 6'h00, 0, "R2 set");
        chk_irq("R4 masked off");
        wr(3, 6'h08, 0, 64'h0);
        rd(3, 6'h00, 0, "R2 zero write keeps");
        wr(3, 6'h08, 0, 64'h100);
        rd(3, 6'h00, 0, "R2 accumulate");
        // R4: mask and irq
        wr(3, 6'h04, 0, 64'h100);
        chk_irq("R4 irq on");
        rd(3, 6'h04, 0, "R4 mask readback");
        wr(3, 6'h04, 0, 64'h2);
        chk_irq("R4 irq off");
        wr(3, 6'h04, 0, 64'h1);
        chk_irq("R4 irq bit0");
        // R3: clear port
        wr(3, 6'h0C, 0, 64'h4);
        rd(3, 6'h00, 0, "R3 partial clear");
        wr(3, 6'h0C, 0, {32'h0, m_pend[3]});
        rd(3, 6'h00, 0, "R3 write back clears");
        chk_irq("R3 irq drops");
        // R5: message slots in handoff order
        wr(9, 6'h38, 1, 64'hDDDD_0000_0000_0003);
        wr(9, 6'h30, 1, 64'hCCCC_0000_0000_0002);
        wr(9, 6'h28, 1, 64'hBBBB_0000_0000_0001);
        wr(9, 6'h20, 1, 64'hAAAA_5555_1234_0000);
        for (int k = 0; k < 4; k++) rd(9, 6'(6'h20 + 8 * k), 1, "R5 slot");
        wr(9, 6'h20, 1, 64'h0);
        rd(9, 6'h20, 1, "R5 slot0 zeroed");
        rd(9, 6'h28, 1, "R5 slot1 kept");
        // R6: write-only ports read zero
        wr(5, 6'h08, 0, 64'hF0);
        rd(5, 6'h08, 0, "R6 set reads zero");
        rd(5, 6'h0C, 0, "R6 clear reads zero");
        // R7: size mismatch
        wr(5, 6'h08, 1, 64'hF00);
        rd(5, 6'h00, 0, "R7 wide set ignored");
        wr(9, 6'h30, 0, 64'h1111);
        rd(9, 6'h30, 1, "R7 narrow msg ignored");
        rd(5, 6'h00, 1, "R7 wide read zero");
        rd(9, 6'h20, 0, "R7 narrow msg read zero");
        wr(5, 6'h14, 0, 64'hFFFF);
        rd(5, 6'h00, 0, "R7 unmapped ignored");
        // R9: pending word read-only
        wr(5, 6'h00, 0, 64'hFFFF_FFFF);
        rd(5, 6'h00, 0, "R9 pend read-only");
        // R8: isolation across cores
        for (int i = 0; i < 16; i++) wr(i, 6'h04, 0, 64'hFFFF_FFFF);
        chk_irq("R8 only core5 pending");
        wr(5, 6'h0C, 0, 64'hFFFF_FFFF);
        wr(15, 6'h08, 0, 64'h8000_0000);
        chk_irq("R8 core15 only");
        rd(14, 6'h00, 0, "R8 neighbour untouched");
        rd(15, 6'h00, 0, "R8 target set");
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule